// File: doc/BRIEF.md
# Super I/O Configuration Register Unit

This block holds the setup of a legacy peripheral cluster: a parallel port, two serial ports, a floppy controller and an IDE controller. Software reaches it through a pair of byte addresses on a simple strobe bus. The even address is the index port, and writing it selects one of three internal 8-bit registers. The odd address is the data port, which reads or writes the selected register. The three registers are a function-enable register, a resource-map register and a power/test register.

Straight after reset, the first read of the index port returns an identification byte. After that, index reads return the selected index. At reset, all three registers load from fixed tables selected by a 5-bit strap input. A data write to the power/test register that sets its lock bit freezes the enable and map registers until the next reset.

From the register contents the block continuously decodes the following for each peripheral: an enable flag, an I/O base address and an interrupt number. The peripherals themselves sit outside the block. They follow these outputs. A one-cycle pulse tells them when a register has taken a new value.

Top module: `sio_cfg_unit`

## Requirements
- R1: The port answers only when bus_addr[15:1] equals BASE_ADDR[15:1] (default base 0x398). bus_addr[0]=0 selects the index port and 1 selects the data port. A write outside the pair changes nothing, and bus_rdata is 0x00 whenever there is no read to the pair.
- R2: The first index-port read after reset returns 0x88. Every later index read returns the selected index.
- R3: An index-port write stores bus_wdata as the selected index and ends the identification phase, even if no read happened before it.
- R4: The selected index picks the register for data-port reads and writes: 0 is the enable register, 1 the map register and 2 the power/test register. With any other index, a data read returns 0x00 and a data write is dropped.
- R5: Reset, sampled synchronously with rst_n low, sets the index to 0, restarts the identification phase and loads the registers from 32-entry tables indexed by strap. The tables, listed from strap 0 to 31, are:
  - Enable register: 0x4F for straps 0 to 5, 0x4B for 6 to 11, 0x0F for 12 to 15, 0x49 for 16 to 19, 0x07 for 20 to 23, 0x47 for 24 to 29, 0x08 for 30 and 0x00 for 31.
  - Map register: 10 11 11 39 24 38 00 01 01 09 08 08 10 11 39 24 00 01 01 00 10 11 39 24 10 11 11 39 24 38 10 10 (hex).
  - Power/test register: 0x02 for strap 31 and 0x00 for every other strap.
- R6: Enable register bits: bit0 enables the parallel port, bits 1 and 2 enable the first and second serial ports, bit3 enables the floppy controller and bit6 enables the IDE controller. The floppy base is 0x370 when bit5 is set and 0x3F0 when it is clear. The IDE base is 0x170 when bit7 is set and 0x1F0 when it is clear.
- R7: The IDE alternate base always equals the IDE base plus 0x206. The floppy IRQ is always 6 and the IDE IRQ is always 14.
- R8: Map register bits [1:0] choose the parallel base and IRQ:
  - Code 0: base 0x378, with IRQ 7 if power/test bit3 is set and IRQ 5 otherwise.
  - Code 1: base 0x3BC, IRQ 7.
  - Code 2: base 0x278, IRQ 5.
  - Code 3: base 0, IRQ 0.
- R9: Serial port n (0 or 1) uses map bits [2n+3:2n+2] as its code. Code 0 gives base 0x3F8 and code 1 gives 0x2F8. For codes 2 and 3 the base comes from a table indexed by map bits [7:6]:
  - Code 2: 0x3E8, 0x338, 0x2E8, 0x220.
  - Code 3: 0x2E8, 0x238, 0x2E0, 0x228.
  Port 0 takes the low half of uart_base and uart_irq.
- R10: A serial port's IRQ is 3 when its code is odd and 4 when it is even.
- R11: A data write that a register accepts shows on the decoded outputs and read-back after the next clock edge. cfg_changed is high for exactly the cycle after each accepted write and low otherwise.
- R12: Once power/test bit6 (the lock) is set, data writes to the enable and map registers are dropped. Writes to the power/test register still land, but bit6 stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap | input | 5 | Reset-table selector |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port I/O base |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | Serial port enables |
| uart_base | output | 32 | Serial port bases, 16 bits each |
| uart_irq | output | 8 | Serial port IRQs, 4 bits each |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 16 | Floppy controller base |
| fdc_irq | output | 4 | Floppy controller IRQ |
| ide_en | output | 1 | IDE controller enable |
| ide_base | output | 16 | IDE command block base |
| ide_alt_base | output | 16 | IDE control block base |
| ide_irq | output | 4 | IDE controller IRQ |
| cfg_changed | output | 1 | One-cycle pulse after an accepted data write |

## Verification
bus_rdata is combinational, so it is due in the same cycle as the read strobe. The bench samples it one time unit after driving the strobe, before the clock edge that consumes the access. Register contents, decoded outputs, cfg_changed, the selected index and the end of the identification phase all move at the one edge that takes the access. Every comparison of these against the reference model happens at the falling edge that follows that edge.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int BYTE_W   = 8;
  localparam int IOA_W    = 16;
  localparam int IRQ_W    = 4;
  localparam int STRAP_W  = 5;
  localparam int NUM_UART = 2;

  localparam logic [BYTE_W-1:0] ID_CODE   = 8'h88;
  localparam logic [BYTE_W-1:0] LOCK_MASK = 8'h40;
  localparam logic [BYTE_W-1:0] IDX_ENA   = 8'd0;
  localparam logic [BYTE_W-1:0] IDX_MAP   = 8'd1;
  localparam logic [BYTE_W-1:0] IDX_PWR   = 8'd2;

  typedef struct packed {
    logic [BYTE_W-1:0] ena;
    logic [BYTE_W-1:0] map;
    logic [BYTE_W-1:0] pwr;
  } cfg_regs_t;

  function automatic logic [BYTE_W-1:0] ena_default(input logic [STRAP_W-1:0] s);
    if (s <= 5'd5)       return 8'h4F;
    else if (s <= 5'd11) return 8'h4B;
    else if (s <= 5'd15) return 8'h0F;
    else if (s <= 5'd19) return 8'h49;
    else if (s <= 5'd23) return 8'h07;
    else if (s <= 5'd29) return 8'h47;
    else if (s == 5'd30) return 8'h08;
    else                 return 8'h00;
  endfunction

  function automatic logic [BYTE_W-1:0] map_default(input logic [STRAP_W-1:0] s);
    logic [BYTE_W-1:0] v;
    case (s)
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31:      v = 8'h10;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:       v = 8'h11;
      5'd7, 5'd8, 5'd17, 5'd18:                     v = 8'h01;
      5'd3, 5'd14, 5'd22, 5'd27:                    v = 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:                    v = 8'h24;
      5'd5, 5'd29:                                  v = 8'h38;
      5'd9:                                         v = 8'h09;
      5'd10, 5'd11:                                 v = 8'h08;
      default:                                      v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic [BYTE_W-1:0] pwr_default(input logic [STRAP_W-1:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

  function automatic logic [IOA_W-1:0] par_base_of(input logic [1:0] code);
    case (code)
      2'd0:    return 16'h0378;
      2'd1:    return 16'h03BC;
      2'd2:    return 16'h0278;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [IRQ_W-1:0] par_irq_of(input logic [1:0] code, input logic hi);
    case (code)
      2'd0:    return hi ? 4'd7 : 4'd5;
      2'd1:    return 4'd7;
      2'd2:    return 4'd5;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [IOA_W-1:0] uart_base_of(input logic [1:0] code, input logic [1:0] alt);
    logic [IOA_W-1:0] b;
    case (code)
      2'd0: b = 16'h03F8;
      2'd1: b = 16'h02F8;
      2'd2: begin
        case (alt)
          2'd0:    b = 16'h03E8;
          2'd1:    b = 16'h0338;
          2'd2:    b = 16'h02E8;
          default: b = 16'h0220;
        endcase
      end
      default: begin
        case (alt)
          2'd0:    b = 16'h02E8;
          2'd1:    b = 16'h0238;
          2'd2:    b = 16'h02E0;
          default: b = 16'h0228;
        endcase
      end
    endcase
    return b;
  endfunction

  function automatic logic [IRQ_W-1:0] uart_irq_of(input logic [1:0] code);
    return code[0] ? 4'd3 : 4'd4;
  endfunction

endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [STRAP_W-1:0]   strap,
  input  logic                 acc_wr,
  input  logic                 acc_rd,
  input  logic                 acc_data,
  input  logic [BYTE_W-1:0]    wdata,
  output cfg_regs_t            regs,
  output logic [BYTE_W-1:0]    sel_idx,
  output logic                 id_phase,
  output logic                 wr_taken,
  output logic [BYTE_W-1:0]    rdata
);

  logic idx_wr, idx_rd, dat_wr, dat_rd, locked;
  logic wr_ena, wr_map, wr_pwr;

  assign idx_wr = acc_wr & ~acc_data;
  assign idx_rd = acc_rd & ~acc_data;
  assign dat_wr = acc_wr &  acc_data;
  assign dat_rd = acc_rd &  acc_data;
  assign locked = |(regs.pwr & LOCK_MASK);

  assign wr_ena = dat_wr && (sel_idx == IDX_ENA) && !locked;
  assign wr_map = dat_wr && (sel_idx == IDX_MAP) && !locked;
  assign wr_pwr = dat_wr && (sel_idx == IDX_PWR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs.ena <= ena_default(strap);
      regs.map <= map_default(strap);
      regs.pwr <= pwr_default(strap);
      sel_idx  <= IDX_ENA;
      id_phase <= 1'b1;
      wr_taken <= 1'b0;
    end else begin
      if (idx_wr) begin
        sel_idx  <= wdata;
        id_phase <= 1'b0;
      end else if (idx_rd) begin
        id_phase <= 1'b0;
      end
      if (wr_ena) regs.ena <= wdata;
      if (wr_map) regs.map <= wdata;
      if (wr_pwr) regs.pwr <= wdata | (regs.pwr & LOCK_MASK);
      wr_taken <= wr_ena | wr_map | wr_pwr;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx_rd) begin
      rdata = id_phase ? ID_CODE : sel_idx;
    end else if (dat_rd) begin
      case (sel_idx)
        IDX_ENA: rdata = regs.ena;
        IDX_MAP: rdata = regs.map;
        IDX_PWR: rdata = regs.pwr;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
(
  input  logic [3:0]               en_bits,
  input  logic                     fdc_alt,
  input  logic                     ide_on,
  input  logic                     ide_alt,
  input  logic [BYTE_W-1:0]        map,
  input  logic                     par_hi_irq,
  output logic                     par_en,
  output logic [IOA_W-1:0]         par_base,
  output logic [IRQ_W-1:0]         par_irq,
  output logic [NUM_UART-1:0]      uart_en,
  output logic [NUM_UART*IOA_W-1:0] uart_base,
  output logic [NUM_UART*IRQ_W-1:0] uart_irq,
  output logic                     fdc_en,
  output logic [IOA_W-1:0]         fdc_base,
  output logic [IRQ_W-1:0]         fdc_irq,
  output logic                     ide_en,
  output logic [IOA_W-1:0]         ide_base,
  output logic [IOA_W-1:0]         ide_alt_base,
  output logic [IRQ_W-1:0]         ide_irq
);

  localparam logic [IOA_W-1:0] IDE_CTL_OFS = 16'h0206;

  assign par_en   = en_bits[0];
  assign par_base = par_base_of(map[1:0]);
  assign par_irq  = par_irq_of(map[1:0], par_hi_irq);

  for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
    logic [1:0] code;
    assign code = map[2*u+3 -: 2];
    assign uart_en[u]                    = en_bits[u+1];
    assign uart_base[u*IOA_W +: IOA_W]   = uart_base_of(code, map[7:6]);
    assign uart_irq[u*IRQ_W +: IRQ_W]    = uart_irq_of(code);
  end

  assign fdc_en       = en_bits[3];
  assign fdc_base     = fdc_alt ? 16'h0370 : 16'h03F0;
  assign fdc_irq      = 4'd6;
  assign ide_en       = ide_on;
  assign ide_base     = ide_alt ? 16'h0170 : 16'h01F0;
  assign ide_alt_base = ide_base + IDE_CTL_OFS;
  assign ide_irq      = 4'd14;

endmodule

// File: rtl/sio_cfg_unit.sv
module sio_cfg_unit
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0398
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  strap,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        par_en,
  output logic [15:0] par_base,
  output logic [3:0]  par_irq,
  output logic [1:0]  uart_en,
  output logic [31:0] uart_base,
  output logic [7:0]  uart_irq,
  output logic        fdc_en,
  output logic [15:0] fdc_base,
  output logic [3:0]  fdc_irq,
  output logic        ide_en,
  output logic [15:0] ide_base,
  output logic [15:0] ide_alt_base,
  output logic [3:0]  ide_irq,
  output logic        cfg_changed
);

  logic        acc_hit;
  cfg_regs_t   regs_q;
  logic [7:0]  sel_idx_q;
  logic        id_phase_q;

  assign acc_hit = (bus_addr[15:1] == BASE_ADDR[15:1]);

  sio_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap    (strap),
    .acc_wr   (bus_wr & acc_hit),
    .acc_rd   (bus_rd & acc_hit),
    .acc_data (bus_addr[0]),
    .wdata    (bus_wdata),
    .regs     (regs_q),
    .sel_idx  (sel_idx_q),
    .id_phase (id_phase_q),
    .wr_taken (cfg_changed),
    .rdata    (bus_rdata)
  );

  sio_cfg_decode u_dec (
    .en_bits      (regs_q.ena[3:0]),
    .fdc_alt      (regs_q.ena[5]),
    .ide_on       (regs_q.ena[6]),
    .ide_alt      (regs_q.ena[7]),
    .map          (regs_q.map),
    .par_hi_irq   (regs_q.pwr[3]),
    .par_en       (par_en),
    .par_base     (par_base),
    .par_irq      (par_irq),
    .uart_en      (uart_en),
    .uart_base    (uart_base),
    .uart_irq     (uart_irq),
    .fdc_en       (fdc_en),
    .fdc_base     (fdc_base),
    .fdc_irq      (fdc_irq),
    .ide_en       (ide_en),
    .ide_base     (ide_base),
    .ide_alt_base (ide_alt_base),
    .ide_irq      (ide_irq)
  );

endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_a0,
  input logic [7:0]  bus_wdata,
  input logic        acc_hit,
  input logic        cfg_changed,
  input logic [7:0]  ena,
  input logic [7:0]  map,
  input logic [7:0]  pwr,
  input logic [7:0]  sel_idx,
  input logic        id_phase,
  input logic [15:0] par_base,
  input logic [3:0]  par_irq,
  input logic [7:0]  uart_irq
);

  AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bus_wr && !acc_hit) |-> $stable(ena) && $stable(map) && $stable(pwr)); // R1

  AST_INDEX_WRITE_ENDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bus_wr && acc_hit && !bus_a0) |-> !id_phase && (sel_idx == $past(bus_wdata))); // R3

  AST_RESET_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (sel_idx == 8'd0) && id_phase); // R5

  AST_PAR_NONE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (par_base == 16'h0000) |-> (par_irq == 4'd0)); // R8

  AST_UART0_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_irq[3:0] == 4'd3) || (uart_irq[3:0] == 4'd4)); // R10

  AST_UART1_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_irq[7:4] == 4'd3) || (uart_irq[7:4] == 4'd4)); // R10

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> $past(bus_wr && acc_hit && bus_a0)); // R11

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(pwr[6]) |-> $stable(ena) && $stable(map) && pwr[6]); // R12

endmodule

bind sio_cfg_unit sio_cfg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_a0      (bus_addr[0]),
  .bus_wdata   (bus_wdata),
  .acc_hit     (acc_hit),
  .cfg_changed (cfg_changed),
  .ena         (regs_q.ena),
  .map         (regs_q.map),
  .pwr         (regs_q.pwr),
  .sel_idx     (sel_idx_q),
  .id_phase    (id_phase_q),
  .par_base    (par_base),
  .par_irq     (par_irq),
  .uart_irq    (uart_irq)
);

// File: tb/tb_sio_cfg_unit.sv
module tb_sio_cfg_unit;

  localparam int CLK_PERIOD = 10;
  localparam int BASE = 'h398;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap = 5'd1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        par_en, fdc_en, ide_en, cfg_changed;
  logic [15:0] par_base, fdc_base, ide_base, ide_alt_base;
  logic [3:0]  par_irq, fdc_irq, ide_irq;
  logic [1:0]  uart_en;
  logic [31:0] uart_base;
  logic [7:0]  uart_irq;

  sio_cfg_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // reference model state
  int m_reg[3];
  int m_idx;
  bit m_id;
  bit m_pulse;
  int last_rd;

  int t_ena[32] = '{'h4F,'h4F,'h4F,'h4F,'h4F,'h4F,'h4B,'h4B,'h4B,'h4B,'h4B,'h4B,'h0F,'h0F,'h0F,'h0F,
                    'h49,'h49,'h49,'h49,'h07,'h07,'h07,'h07,'h47,'h47,'h47,'h47,'h47,'h47,'h08,'h00};
  int t_map[32] = '{'h10,'h11,'h11,'h39,'h24,'h38,'h00,'h01,'h01,'h09,'h08,'h08,'h10,'h11,'h39,'h24,
                    'h00,'h01,'h01,'h00,'h10,'h11,'h39,'h24,'h10,'h11,'h11,'h39,'h24,'h38,'h10,'h10};
  int par_tab[4] = '{'h378, 'h3BC, 'h278, 0};
  int par_irq_tab[4] = '{-1, 7, 5, 0};
  int ut2[4] = '{'h3E8, 'h338, 'h2E8, 'h220};
  int ut3[4] = '{'h2E8, 'h238, 'h2E0, 'h228};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int m_read(input int a, input bit rd);
    if (!rd || (a / 2) != (BASE / 2)) return 0;
    if (a % 2 == 0) return m_id ? 'h88 : m_idx;
    if (m_idx < 3) return m_reg[m_idx];
    return 0;
  endfunction

  function automatic int exp_uart_base(input int n);
    int code = (m_reg[1] >> (2 * n + 2)) % 4;
    int col  = m_reg[1] / 64;
    if (code == 0) return 'h3F8;
    if (code == 1) return 'h2F8;
    return (code == 2) ? ut2[col] : ut3[col];
  endfunction

  task automatic compare_all();
    int pc = m_reg[1] % 4;
    int ide_b = (m_reg[0] >= 128) ? 'h170 : 'h1F0;
    chk("R6", "par_en", par_en, m_reg[0] % 2);
    chk("R6", "uart_en", uart_en, (m_reg[0] / 2) % 4);
    chk("R6", "fdc_en", fdc_en, (m_reg[0] / 8) % 2);
    chk("R6", "ide_en", ide_en, (m_reg[0] / 64) % 2);
    chk("R6", "fdc_base", fdc_base, ((m_reg[0] / 32) % 2) ? 'h370 : 'h3F0);
    chk("R6", "ide_base", ide_base, ide_b);
    chk("R7", "ide_alt_base", ide_alt_base, ide_b + 'h206);
    chk("R7", "fdc_irq", fdc_irq, 6);
    chk("R7", "ide_irq", ide_irq, 14);
    chk("R8", "par_base", par_base, par_tab[pc]);
    chk("R8", "par_irq", par_irq, (pc == 0) ? (((m_reg[2] / 8) % 2) ? 7 : 5) : par_irq_tab[pc]);
    chk("R9", "uart0_base", uart_base[15:0], exp_uart_base(0));
    chk("R9", "uart1_base", uart_base[31:16], exp_uart_base(1));
    chk("R10", "uart0_irq", uart_irq[3:0], (((m_reg[1] / 4) % 2) == 1) ? 3 : 4);
    chk("R10", "uart1_irq", uart_irq[7:4], (((m_reg[1] / 16) % 2) == 1) ? 3 : 4);
    chk("R11", "cfg_changed", cfg_changed, m_pulse);
  endtask

  // one bus cycle: drive in low phase, check rdata, step model at the edge, compare after it
  task automatic cyc(input bit wr, input bit rd, input int a, input int d);
    int e;
    bus_wr = wr; bus_rd = rd; bus_addr = a[15:0]; bus_wdata = d[7:0];
    #1;
    e = m_read(a, rd);
    last_rd = bus_rdata;
    chk("R4", "bus_rdata", bus_rdata, e);
    @(posedge clk);
    m_pulse = 0;
    if ((a / 2) == (BASE / 2)) begin
      if (wr && a % 2 == 0) begin m_idx = d; m_id = 0; end
      else if (rd && a % 2 == 0) m_id = 0;
      else if (wr && a % 2 == 1) begin
        if (m_idx == 2) begin m_reg[2] = d | (m_reg[2] & 'h40); m_pulse = 1; end
        else if (m_idx < 2 && (m_reg[2] & 'h40) == 0) begin m_reg[m_idx] = d; m_pulse = 1; end
      end
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    compare_all();
  endtask

  task automatic do_reset(input int s);
    rst_n = 0; strap = s[4:0];
    @(posedge clk);
    m_reg[0] = t_ena[s]; m_reg[1] = t_map[s]; m_reg[2] = (s == 31) ? 2 : 0;
    m_idx = 0; m_id = 1; m_pulse = 0;
    @(negedge clk);
    rst_n = 1;
    compare_all();
  endtask

  task automatic wr_idx(input int v);  cyc(1, 0, BASE, v);     endtask
  task automatic wr_dat(input int v);  cyc(1, 0, BASE + 1, v); endtask
  task automatic rd_idx();             cyc(0, 1, BASE, 0);     endtask
  task automatic rd_dat();             cyc(0, 1, BASE + 1, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R5: default strap
    do_reset(1);
    chk("R5", "ide_base default", ide_base, 'h1F0);
    chk("R5", "uart1 base default", uart_base[31:16], 'h2F8);
    // R2: identification then index
    rd_idx(); chk("R2", "first index read", last_rd, 'h88);
    rd_idx(); chk("R2", "second index read", last_rd, 0);
    // R3: index write without prior read
    do_reset(1);
    wr_idx(1); rd_idx(); chk("R3", "index readback", last_rd, 1);
    rd_dat(); chk("R4", "map read", last_rd, 'h11);
    // R11: write map and see pulse
    wr_dat('hF6); chk("R11", "pulse after write", cfg_changed, 1);
    cyc(0, 0, 0, 0); chk("R11", "pulse one cycle", cfg_changed, 0);
    // R8 R9 R10: sweep map with both parallel IRQ options
    for (int p = 0; p < 2; p++) begin
      wr_idx(2); wr_dat(p * 8); wr_idx(1);
      for (int v = 0; v < 256; v++) wr_dat(v);
    end
    // R6 R7: sweep enable register
    wr_idx(0);
    for (int v = 0; v < 256; v++) wr_dat(v);
    // R4: out-of-range index
    wr_idx(3); wr_dat('h55); rd_dat(); chk("R4", "bad index read", last_rd, 0);
    wr_idx(200); wr_dat('hAA); chk("R4", "bad index no pulse", cfg_changed, 0);
    wr_idx(0); rd_dat(); chk("R4", "ena after bad writes", last_rd, 255);
    // R1: foreign addresses
    cyc(1, 0, BASE + 2, 'h01); cyc(1, 0, BASE - 1, 'h00);
    cyc(0, 1, BASE + 3, 0); chk("R1", "foreign read", last_rd, 0);
    rd_dat(); chk("R1", "ena untouched", last_rd, 255);
    // R12: lock
    wr_idx(2); wr_dat('h40);
    wr_idx(0); wr_dat('h00); chk("R12", "locked write no pulse", cfg_changed, 0);
    rd_dat(); chk("R12", "ena frozen", last_rd, 255);
    wr_idx(1); wr_dat('h3C); rd_dat(); chk("R12", "map frozen", last_rd, 255);
    wr_idx(2); wr_dat('h08); rd_dat(); chk("R12", "lock sticky", last_rd, 'h48);
    do_reset(1); wr_idx(0); wr_dat('h01); rd_dat(); chk("R12", "reset unlocks", last_rd, 1);
    // R5: every strap
    for (int s = 0; s < 32; s++) begin
      do_reset(s);
      rd_idx(); chk("R5", "id after reset", last_rd, 'h88);
      rd_dat(); chk("R5", "ena table", last_rd, t_ena[s]);
      wr_idx(1); rd_dat(); chk("R5", "map table", last_rd, t_map[s]);
      wr_idx(2); rd_dat(); chk("R5", "pwr table", last_rd, (s == 31) ? 2 : 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule